// File: doc/BRIEF.md
# Dual-Comparator Tick Timer

This block is a 16-bit up-counter with two compare registers, one setup register and an interrupt line, all reached over a simple 16-bit register bus. The counter advances on one of two clock-enable pulse inputs, a slow source or a fast source. A power-of-two prescaler sits between the chosen source and the counter. Counting can be held off by a sleep input or made to depend on an external gate input.

Each comparator has its own mode. It can be off, match on equality, match on greater-or-equal, or run in event mode. A match is judged on each count step against the value the counter is leaving. A match sets a sticky status bit, which software clears by writing 1 to it.

When the second comparator is in event mode, it also wraps the counter to zero and drives the interrupt output. This gives a periodic or one-shot system tick of compare value + 1 counts. The low twelve setup bits are write-once after reset. The counter can also be read back bit-reversed.

Top module: `gp_tick_timer`

## Requirements
- R1: After reset every register reads 0, the counter does not advance and `tick_irq` is low.
- R2: Registers sit at byte offsets 0 (compare A), 2 (compare B), 4 (counter) and 6 (setup). All except setup bit 12 are read/write. Writes to odd addresses are ignored. A counter write wins over a same-cycle count step and restarts the prescaler.
- R3: The counter advances only while setup bit 15 is 1. Setup bit 4 picks the source: 1 means `fast_tick`, 0 means `slow_tick`. Pulses on the other source have no effect.
- R4: With setup bits 3:0 equal to n, the counter steps once every 2^n pulses of the selected source.
- R5: The first setup write after reset loads bits 11:0 and sets read-only bit 12. Later setup writes change only bits 15:13.
- R6: Mode fields are bits 7:6 for compare A and bits 9:8 for compare B. The codes are 00 off, 01 equal, 10 greater-or-equal and 11 event. On a count step, a comparator whose mode is not off sets its status when the count being left matches. Compare A status is bit 13; compare B status is bit 14. A comparator that is off never sets its status.
- R7: In event mode, a compare B match on a step loads 0 instead of count+1. This gives a period of compare B + 1 steps. `tick_irq` is high exactly while compare B status is set and compare B is in event mode.
- R8: Writing 1 to status bit 13 or 14 clears it, and writing 0 leaves it unchanged. A match in the same cycle as the clearing write keeps the bit set.
- R9: While setup bit 11 is 1 and `sleep_in` is high, the counter holds.
- R10: While setup bit 10 is 1, the counter advances only when `ext_gate_in` is high.
- R11: While setup bit 5 is 1, the counter register reads back bit-reversed (bit i shown at bit 15-i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| slow_tick | input | 1 | Slow source clock-enable pulse |
| fast_tick | input | 1 | Fast source clock-enable pulse |
| sleep_in | input | 1 | Sleep request that can freeze counting |
| ext_gate_in | input | 1 | External count gate |
| tick_irq | output | 1 | Interrupt from compare B in event mode |

## Verification
Several properties are checked on every cycle. These are: the counter stays still while counting is off, and no step happens while sleep-stop is active. Once the lock bit is set, the write-once field stays frozen. A counter write lands exactly. An event-mode match wraps the count to zero. Compare B status persists until a clearing write.

Other behaviours can only be shown by the bench's scenarios. These are the period of the tick, the prescaler ratio and its restart, and the equal versus greater-or-equal distinction. The bench also covers set-beats-clear, address decoding and the reversed readback, where the expected values come from sequences of pulses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 16;
    localparam int PRE_W  = 4;
    localparam int NUM_CMP = 2;

    typedef enum logic [1:0] {
        CMP_OFF = 2'b00,
        CMP_EQ  = 2'b01,
        CMP_GE  = 2'b10,
        CMP_EVT = 2'b11
    } cmp_mode_e;

    // Bit positions are software-visible: the layout is behaviour.
    typedef struct packed {
        logic             run;         // 15
        logic             stat_b;      // 14
        logic             stat_a;      // 13
        logic             locked;      // 12
        logic             sleep_stop;  // 11
        logic             ext_gate;    // 10
        cmp_mode_e        mode_b;      // 9:8
        cmp_mode_e        mode_a;      // 7:6
        logic             rev;         // 5
        logic             fast_sel;    // 4
        logic [PRE_W-1:0] scale;       // 3:0
    } setup_t;

    typedef enum logic [1:0] {
        REG_CMPA  = 2'd0,
        REG_CMPB  = 2'd1,
        REG_COUNT = 2'd2,
        REG_SETUP = 2'd3
    } reg_sel_e;

    function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = v[DATA_W-1-i];
        end
        return r;
    endfunction

    function automatic logic cmp_hit(input cmp_mode_e m,
                                     input logic [DATA_W-1:0] c,
                                     input logic [DATA_W-1:0] ref_v);
        case (m)
            CMP_EQ:           return c == ref_v;
            CMP_GE, CMP_EVT:  return c >= ref_v;
            default:          return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int SCALE_W = PRE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slow_tick,
    input  logic               fast_tick,
    input  logic               fast_sel,
    input  logic [SCALE_W-1:0] scale,
    input  logic               run,
    input  logic               sleep_stop,
    input  logic               sleep_in,
    input  logic               ext_gate,
    input  logic               ext_gate_in,
    input  logic               restart,
    output logic               step
);
    localparam int DIV_W = (1 << SCALE_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] limit;
    logic             src;
    logic             active;

    assign src    = fast_sel ? fast_tick : slow_tick;
    assign active = run && src && !(sleep_stop && sleep_in) && (!ext_gate || ext_gate_in);
    assign span   = (DIV_W+1)'(1) << scale;
    assign limit  = span[DIV_W-1:0] - DIV_W'(1);
    assign step   = active && (div_q == limit) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
        end else if (active) begin
            div_q <= (div_q == limit) ? '0 : div_q + DIV_W'(1);
        end
    end

    logic unused_span;
    assign unused_span = span[DIV_W];

endmodule

// File: rtl/tmr_match.sv
module tmr_match
    import tmr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic      step,
    input  cmp_mode_e mode,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ref_v,
    output logic      hit
);
    assign hit = step && cmp_hit(mode, cnt, ref_v);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         wrap,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step) begin
            cnt <= wrap ? '0 : cnt + W'(1);
        end
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic [NUM_CMP-1:0] hit,
    input  logic [W-1:0]      cnt,
    output setup_t            cfg,
    output logic [W-1:0]      cmp_a,
    output logic [W-1:0]      cmp_b,
    output logic              cnt_load,
    output logic [W-1:0]      bus_rdata
);
    localparam int LOW_W = 12;

    reg_sel_e sel;
    logic     wr_ok;
    logic     setup_wr;

    assign sel      = reg_sel_e'(bus_addr[2:1]);
    assign wr_ok    = bus_wr && !bus_addr[0];
    assign setup_wr = wr_ok && (sel == REG_SETUP);
    assign cnt_load = wr_ok && (sel == REG_COUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_a <= '0;
            cmp_b <= '0;
        end else begin
            if (wr_ok && sel == REG_CMPA) cmp_a <= bus_wdata;
            if (wr_ok && sel == REG_CMPB) cmp_b <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            cfg.stat_a <= (cfg.stat_a && !(setup_wr && bus_wdata[13])) || hit[0];
            cfg.stat_b <= (cfg.stat_b && !(setup_wr && bus_wdata[14])) || hit[1];
            if (setup_wr) begin
                cfg.run <= bus_wdata[15];
                if (!cfg.locked) begin
                    cfg.locked      <= 1'b1;
                    cfg[LOW_W-1:0]  <= bus_wdata[LOW_W-1:0];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr[0]) begin
            case (sel)
                REG_CMPA:  bus_rdata = cmp_a;
                REG_CMPB:  bus_rdata = cmp_b;
                REG_COUNT: bus_rdata = cfg.rev ? bit_rev(cnt) : cnt;
                default:   bus_rdata = cfg;
            endcase
        end
    end

    logic unused_wbit;
    assign unused_wbit = bus_wdata[12];

endmodule

// File: rtl/gp_tick_timer.sv
module gp_tick_timer
    import tmr_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              sleep_in,
    input  logic              ext_gate_in,
    output logic              tick_irq
);
    setup_t                cfg;
    logic [W-1:0]          cmp_a_q;
    logic [W-1:0]          cmp_b_q;
    logic [W-1:0]          cnt_q;
    logic                  cnt_load;
    logic                  step;
    logic                  wrap;
    logic [NUM_CMP-1:0]    hit;
    logic [NUM_CMP-1:0][W-1:0] ref_v;
    cmp_mode_e             mode_v [NUM_CMP];

    assign ref_v[0]  = cmp_a_q;
    assign ref_v[1]  = cmp_b_q;
    assign mode_v[0] = cfg.mode_a;
    assign mode_v[1] = cfg.mode_b;

    tmr_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hit       (hit),
        .cnt       (cnt_q),
        .cfg       (cfg),
        .cmp_a     (cmp_a_q),
        .cmp_b     (cmp_b_q),
        .cnt_load  (cnt_load),
        .bus_rdata (bus_rdata)
    );

    tmr_prescale #(.SCALE_W(PRE_W)) u_pre (
        .clk         (clk),
        .rst         (rst),
        .slow_tick   (slow_tick),
        .fast_tick   (fast_tick),
        .fast_sel    (cfg.fast_sel),
        .scale       (cfg.scale),
        .run         (cfg.run),
        .sleep_stop  (cfg.sleep_stop),
        .sleep_in    (sleep_in),
        .ext_gate    (cfg.ext_gate),
        .ext_gate_in (ext_gate_in),
        .restart     (cnt_load),
        .step        (step)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        tmr_match #(.W(W)) u_match (
            .step  (step),
            .mode  (mode_v[g]),
            .cnt   (cnt_q),
            .ref_v (ref_v[g]),
            .hit   (hit[g])
        );
    end

    assign wrap = hit[1] && (cfg.mode_b == CMP_EVT);

    tmr_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (bus_wdata),
        .step     (step),
        .wrap     (wrap),
        .cnt      (cnt_q)
    );

    assign tick_irq = cfg.stat_b && (cfg.mode_b == CMP_EVT);

endmodule

// File: rtl/gp_tick_timer_chk.sv
module gp_tick_timer_chk
    import tmr_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic              sleep_in,
    input setup_t            cfg,
    input logic [W-1:0]      cnt_q,
    input logic [W-1:0]      cmp_b_q,
    input logic              step
);
    logic cnt_wr;
    logic clr_b;
    assign cnt_wr = bus_wr && bus_addr == 3'd4;
    assign clr_b  = bus_wr && bus_addr == 3'd6 && bus_wdata[14];

    p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!cfg.run && !cnt_wr) |=> $stable(cnt_q));

    p_step_needs_run_r3: assert property (@(posedge clk) disable iff (rst)
        step |-> cfg.run);

    p_lock_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        cfg.locked |=> (cfg.locked && $stable(cfg[11:0])));

    p_cnt_write_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt_q == $past(bus_wdata)));

    p_event_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (step && !cnt_wr && cfg.mode_b == CMP_EVT && cnt_q >= cmp_b_q) |=> (cnt_q == '0));

    p_stat_b_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg.stat_b && !clr_b) |=> cfg.stat_b);

    p_sleep_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg.sleep_stop && sleep_in) |-> !step);

endmodule

bind gp_tick_timer gp_tick_timer_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sleep_in  (sleep_in),
    .cfg       (cfg),
    .cnt_q     (cnt_q),
    .cmp_b_q   (cmp_b_q),
    .step      (step)
);

// File: tb/gp_tick_timer_tb.sv
`timescale 1ns/1ps
module gp_tick_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        slow_tick = 1'b0;
    logic        fast_tick = 1'b0;
    logic        sleep_in = 1'b0;
    logic        ext_gate_in = 1'b1;
    logic        tick_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gp_tick_timer u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slow_tick(slow_tick),
        .fast_tick(fast_tick), .sleep_in(sleep_in), .ext_gate_in(ext_gate_in),
        .tick_irq(tick_irq)
    );

    typedef struct {
        bit          is_irq;
        logic [2:0]  a;
        logic [15:0] exp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    // Monitor: samples 1 ns after each falling edge and compares queued items.
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (it.is_irq) begin
                    if (tick_irq !== it.exp[0]) begin
                        fails++;
                        $display("FAIL %s irq: actual %0b expected %0b", it.tag, tick_irq, it.exp[0]);
                    end
                end else if (bus_rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s addr %0d: actual 0x%04h expected 0x%04h", it.tag, it.a, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [15:0] v, input string tag);
        bus_addr = a;
        sb_q.push_back('{1'b0, a, v, tag});
        @(negedge clk);
    endtask

    task automatic expect_irq(input bit v, input string tag);
        sb_q.push_back('{1'b1, 3'd0, {15'd0, v}, tag});
        @(negedge clk);
    endtask

    task automatic pulses(input bit fast, input int n);
        for (int i = 0; i < n; i++) begin
            if (fast) fast_tick = 1'b1; else slow_tick = 1'b1;
            @(negedge clk);
            fast_tick = 1'b0; slow_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // ---------- Scenario A: reset, map, event-mode tick ----------
        do_reset();
        expect_rd(3'd0, 16'h0000, "R1 cmpA");
        expect_rd(3'd2, 16'h0000, "R1 cmpB");
        expect_rd(3'd4, 16'h0000, "R1 count");
        expect_rd(3'd6, 16'h0000, "R1 setup");
        expect_irq(1'b0, "R1");
        pulses(1'b1, 2);
        expect_rd(3'd4, 16'h0000, "R1 stopped after reset");

        bus_write(3'd0, 16'h1234);
        bus_write(3'd1, 16'hFFFF);
        bus_write(3'd2, 16'h0004);
        bus_write(3'd4, 16'h0007);
        expect_rd(3'd0, 16'h1234, "R2 odd write ignored");
        expect_rd(3'd2, 16'h0004, "R2 cmpB");
        expect_rd(3'd4, 16'h0007, "R2 count");
        pulses(1'b1, 3);
        expect_rd(3'd4, 16'h0007, "R3 no run");
        bus_write(3'd4, 16'h0000);

        bus_write(3'd6, 16'hE310);
        expect_rd(3'd6, 16'h9310, "R5 first write + lock");
        pulses(1'b1, 3);
        expect_rd(3'd4, 16'h0003, "R3 fast counts");
        pulses(1'b0, 2);
        expect_rd(3'd4, 16'h0003, "R3 slow ignored");
        pulses(1'b1, 1);
        expect_rd(3'd4, 16'h0004, "R7 reach compare");
        expect_irq(1'b0, "R7 before wrap");
        pulses(1'b1, 1);
        expect_rd(3'd4, 16'h0000, "R7 wrap");
        expect_irq(1'b1, "R7 irq");
        expect_rd(3'd6, 16'hD310, "R7 stat B, R6 off A clear");
        pulses(1'b1, 4);
        expect_rd(3'd4, 16'h0004, "R7 period");
        expect_irq(1'b1, "R8 sticky");
        bus_write(3'd6, 16'h8000);
        expect_rd(3'd6, 16'hD310, "R8 write 0 keeps");
        bus_write(3'd6, 16'hC000);
        expect_rd(3'd6, 16'h9310, "R8 W1C");
        expect_irq(1'b0, "R8 irq cleared");
        // clearing write in the same cycle as a matching step
        bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 16'hC000; fast_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; fast_tick = 1'b0;
        expect_irq(1'b1, "R8 set beats clear");
        expect_rd(3'd4, 16'h0000, "R7 wrap on clear cycle");
        bus_write(3'd6, 16'hC000);
        expect_irq(1'b0, "R8 cleared again");

        bus_write(3'd6, 16'h8001);
        expect_rd(3'd6, 16'h9310, "R5 write-once");
        bus_write(3'd6, 16'h0000);
        expect_rd(3'd6, 16'h1310, "R5 run bit writable");
        pulses(1'b1, 2);
        expect_rd(3'd4, 16'h0000, "R3 run off holds");
        bus_write(3'd6, 16'h8000);
        bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 16'h0002; fast_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; fast_tick = 1'b0;
        expect_rd(3'd4, 16'h0002, "R2 write beats step");
        pulses(1'b1, 1);
        expect_rd(3'd4, 16'h0003, "R2 counts after write");

        // ---------- Scenario B: prescale, EQ/GE, reverse ----------
        do_reset();
        bus_write(3'd0, 16'h0001);
        bus_write(3'd2, 16'h0002);
        bus_write(3'd6, 16'h8262);
        pulses(1'b0, 3);
        expect_rd(3'd4, 16'h0000, "R4 below ratio");
        pulses(1'b0, 1);
        expect_rd(3'd4, 16'h8000, "R4 step, R11 reversed");
        pulses(1'b0, 4);
        expect_rd(3'd6, 16'hB262, "R6 equal hit A");
        pulses(1'b0, 4);
        expect_rd(3'd6, 16'hF262, "R6 GE hit B");
        expect_irq(1'b0, "R7 no irq in GE");
        expect_rd(3'd4, 16'hC000, "R7 no wrap in GE, R11");
        bus_write(3'd6, 16'hA000);
        expect_rd(3'd6, 16'hD262, "R8 clear A only");
        pulses(1'b0, 4);
        expect_rd(3'd6, 16'hD262, "R6 equal not re-hit");
        pulses(1'b0, 2);
        bus_write(3'd4, 16'h0010);
        pulses(1'b0, 3);
        expect_rd(3'd4, 16'h0800, "R2 prescaler restarted");
        pulses(1'b0, 1);
        expect_rd(3'd4, 16'h8800, "R4 step after restart");

        // ---------- Scenario C: sleep stop and external gate ----------
        do_reset();
        bus_write(3'd6, 16'h8C10);
        expect_rd(3'd6, 16'h9C10, "R5 load");
        pulses(1'b1, 1);
        expect_rd(3'd4, 16'h0001, "R10 gate high counts");
        sleep_in = 1'b1;
        pulses(1'b1, 2);
        expect_rd(3'd4, 16'h0001, "R9 sleep holds");
        sleep_in = 1'b0;
        ext_gate_in = 1'b0;
        pulses(1'b1, 2);
        expect_rd(3'd4, 16'h0001, "R10 gate low holds");
        ext_gate_in = 1'b1;
        pulses(1'b1, 1);
        expect_rd(3'd4, 16'h0002, "R10 resumes");
        expect_rd(3'd6, 16'h9C10, "R6 off modes never set");

        @(negedge clk);
        finish_run();
    end

endmodule